// File: doc/BRIEF.md
# Grouped Interrupt Aggregator

This block gathers a large number of peripheral interrupt lines into nineteen numbered groups (numbers 8 to 26), each with 32 source positions. Inside each group an asserted source sets a sticky status bit. A per-source enable selects which latched bits count. The AND of status and enable forms the group's result word. The OR of a result word becomes that group's single aggregated request, but only while the group's bit in a global block-enable word is set.

Some groups may also present their result bits one by one on direct per-source request lines. This happens only when a single global direct-enable control bit is set. Software reaches every register through a plain 32-bit read/write bus with byte addresses. Write strobes act in the clock edge they are sampled. A read strobe returns data one cycle later.

Group windows are 0x14 bytes wide, packed from address 0 with group 8 first. Within a window the offsets are: 0x0 status (write 1 to clear), 0x4 enable-set, 0x8 enable-clear and 0xC result. The word at 0x10 is reserved. The global registers sit at 0x200 (block-enable set), 0x204 (block-enable clear), 0x208 (block-enable readback) and 0x20C (direct-enable control, bit 0).

Top module: `grp_irq_aggr`

## Requirements
- R1: After reset all status bits, enables, block enables and the direct-enable bit are 0, every request output is low and every register reads 0.
- R2: A status bit of an implemented position sets in the cycle its source input is high and stays set until software writes 1 to that bit at window offset 0x0. Zero bits written there leave status unchanged.
- R3: When a source is high in the same cycle as a write-1-to-clear of its status bit, the bit ends up set.
- R4: Writing 1s at offset 0x4 sets those enable bits and writing 1s at offset 0x8 clears them. Zero bits leave enables unchanged, and both offsets read back the current enable word.
- R5: Offset 0xC reads status AND enable. Writes to it have no effect.
- R6: Request output k (group number k+8) is high exactly when its result word is non-zero and block-enable bit k+8 is 1.
- R7: Writing 1s to 0x200 sets block-enable bits and writing 1s to 0x204 clears them. Only bits 8 to 26 are stored, and 0x200, 0x204 and 0x208 all read the block-enable word.
- R8: Direct line g*32+b follows result bit b of group index g when bit 0 at 0x20C is 1 and bit (g+8) of capability mask 0x00BFE000 is 1. Otherwise the line is 0. Bit 0 of 0x20C reads back.
- R9: Source positions that a group does not implement never latch or enable, and they read 0 in every register. With the default build, group index 12 (group 20) implements only positions 3 and 9.
- R10: A read returns its data on the read-data port in the cycle after the read strobe and 0 otherwise. Reserved, unaligned and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W (10) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| src_in | input | NUM_GROUPS*32 (608) | Raw source lines, group index g at bits g*32 upward |
| grp_irq | output | NUM_GROUPS (19) | Aggregated request per group |
| direct_irq | output | NUM_GROUPS*32 (608) | Per-source direct requests |

## Verification
The bench aims at the race between a source pulse and a write-1-to-clear of the same bit. A design where the clear wins would drop that event, and status would read 0 instead of 0x20. It checks that the result register ignores writes and that zero bits written to the set, clear and status addresses change nothing. A design that treats those registers as plain storage would lose its latched state. It drives every source of a sparsely populated group and expects only the implemented positions to appear, and it checks that a group without direct capability never raises a direct line. Gating of each aggregated request by its block-enable bit is checked in both directions, as is the removal of all direct lines when the direct-enable bit is cleared.

// File: rtl/aggr_pkg.sv
package aggr_pkg;

  localparam int unsigned DATA_W    = 32;
  localparam int unsigned WIN_BYTES = 20;

  // window-relative register offsets
  localparam logic [4:0] OFS_STAT   = 5'h00;
  localparam logic [4:0] OFS_EN_SET = 5'h04;
  localparam logic [4:0] OFS_EN_CLR = 5'h08;
  localparam logic [4:0] OFS_RESULT = 5'h0C;

  // global register addresses
  localparam int unsigned ADR_BLK_SET = 'h200;
  localparam int unsigned ADR_BLK_CLR = 'h204;
  localparam int unsigned ADR_BLK_RD  = 'h208;
  localparam int unsigned ADR_DIR_CTL = 'h20C;

  // which source positions exist in a given group index
  function automatic logic [DATA_W-1:0] impl_mask_of(input int unsigned idx);
    case (idx)
      5:       return 32'h0000_001F;
      8:       return 32'h0000_000D;
      12:      return 32'h0000_0208;
      16:      return 32'h0FFF_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  // block-enable bits that correspond to existing groups
  function automatic logic [DATA_W-1:0] blk_mask_of(input int unsigned first,
                                                    input int unsigned cnt);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < DATA_W; i++) begin
      if (i >= first && i < first + cnt) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/aggr_group.sv
module aggr_group
  import aggr_pkg::*;
#(
  parameter int unsigned       ADDR_W = 10,
  parameter int unsigned       BASE   = 0,
  parameter logic [DATA_W-1:0] IMPL   = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] src,
  output logic [DATA_W-1:0] rd_val,
  output logic [DATA_W-1:0] result
);

  localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(BASE + WIN_BYTES);

  logic              win_hit;
  logic [4:0]        ofs;
  logic              wr_stat, wr_set, wr_clr;
  logic [DATA_W-1:0] src_m;
  logic [DATA_W-1:0] stat_q, stat_d;
  logic [DATA_W-1:0] en_q, en_d;
  logic              stat_ce, en_ce;

  // address decode for this window
  always_comb begin
    win_hit = (bus_addr >= LO_A) && (bus_addr < HI_A) && (bus_addr[1:0] == 2'b00);
    ofs     = 5'(bus_addr - LO_A);
    wr_stat = bus_wr && win_hit && (ofs == OFS_STAT);
    wr_set  = bus_wr && win_hit && (ofs == OFS_EN_SET);
    wr_clr  = bus_wr && win_hit && (ofs == OFS_EN_CLR);
  end

  // next state: sources set (and win over clears), writes of 1 clear
  always_comb begin
    src_m   = src & IMPL;
    stat_d  = ((stat_q & ~(wr_stat ? bus_wdata : '0)) | src_m) & IMPL;
    en_d    = ((en_q | (wr_set ? bus_wdata : '0)) & ~(wr_clr ? bus_wdata : '0)) & IMPL;
    stat_ce = wr_stat || (|src_m);
    en_ce   = wr_set || wr_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= '0;
    else if (stat_ce) stat_q <= stat_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_ce) en_q <= en_d;
  end

  assign result = stat_q & en_q;

  always_comb begin
    rd_val = '0;
    if (win_hit) begin
      case (ofs)
        OFS_STAT:   rd_val = stat_q;
        OFS_EN_SET: rd_val = en_q;
        OFS_EN_CLR: rd_val = en_q;
        OFS_RESULT: rd_val = result;
        default:    rd_val = '0;
      endcase
    end
  end

  AST_STAT_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat |=> ((stat_q & $past(bus_wdata & ~src_m)) == '0)); // R2
  AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stat |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R2
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_m) |=> ((stat_q & $past(src_m)) == $past(src_m))); // R3
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_set || wr_clr) |=> $stable(en_q)); // R4

endmodule

// File: rtl/aggr_glb_ctrl.sv
module aggr_glb_ctrl
  import aggr_pkg::*;
#(
  parameter int unsigned ADDR_W     = 10,
  parameter int unsigned NUM_GROUPS = 19,
  parameter int unsigned FIRST_ID   = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     rd_val,
  output logic [NUM_GROUPS-1:0] blk_grp,
  output logic                  dir_en
);

  localparam logic [DATA_W-1:0] BLK_MASK = blk_mask_of(FIRST_ID, NUM_GROUPS);

  logic              hit_set, hit_clr, hit_rd, hit_dir;
  logic [DATA_W-1:0] blk_q, blk_d;
  logic              dir_q, dir_d;
  logic              blk_ce, dir_ce;

  always_comb begin
    hit_set = (bus_addr == ADDR_W'(ADR_BLK_SET));
    hit_clr = (bus_addr == ADDR_W'(ADR_BLK_CLR));
    hit_rd  = (bus_addr == ADDR_W'(ADR_BLK_RD));
    hit_dir = (bus_addr == ADDR_W'(ADR_DIR_CTL));
    blk_ce  = bus_wr && (hit_set || hit_clr);
    dir_ce  = bus_wr && hit_dir;
    blk_d   = ((blk_q | (hit_set ? bus_wdata : '0)) & ~(hit_clr ? bus_wdata : '0)) & BLK_MASK;
    dir_d   = bus_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      blk_q <= '0;
    else if (blk_ce) blk_q <= blk_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= 1'b0;
    else if (dir_ce) dir_q <= dir_d;
  end

  always_comb begin
    rd_val = '0;
    if (hit_set || hit_clr || hit_rd) rd_val = blk_q;
    else if (hit_dir)                 rd_val = {{(DATA_W-1){1'b0}}, dir_q};
  end

  assign blk_grp = blk_q[FIRST_ID +: NUM_GROUPS];
  assign dir_en  = dir_q;

  AST_BLK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit_set) |=> ((blk_q & $past(bus_wdata & BLK_MASK)) == $past(bus_wdata & BLK_MASK))); // R7
  AST_BLK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit_clr) |=> ((blk_q & $past(bus_wdata)) == '0)); // R7
  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && hit_dir) |=> $stable(dir_q)); // R8

endmodule

// File: rtl/aggr_out_stage.sv
module aggr_out_stage
  import aggr_pkg::*;
#(
  parameter int unsigned       NUM_GROUPS = 19,
  parameter int unsigned       FIRST_ID   = 8,
  parameter logic [DATA_W-1:0] DIRECT_CAP = 32'h00BF_E000
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_GROUPS*DATA_W-1:0] result_all,
  input  logic [NUM_GROUPS-1:0]        blk_grp,
  input  logic                         dir_en,
  output logic [NUM_GROUPS-1:0]        grp_irq,
  output logic [NUM_GROUPS*DATA_W-1:0] direct_irq
);

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    assign grp_irq[g] = blk_grp[g] & (|result_all[g*DATA_W +: DATA_W]);

    if (DIRECT_CAP[FIRST_ID + g]) begin : g_direct
      assign direct_irq[g*DATA_W +: DATA_W] = result_all[g*DATA_W +: DATA_W] & {DATA_W{dir_en}};
    end else begin : g_aggr_only
      assign direct_irq[g*DATA_W +: DATA_W] = '0;
    end

    AST_GRP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !blk_grp[g] |-> !grp_irq[g]); // R6
  end

  AST_DIRECT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_en |-> (direct_irq == '0)); // R8

endmodule

// File: rtl/grp_irq_aggr.sv
module grp_irq_aggr
  import aggr_pkg::*;
#(
  parameter int unsigned       NUM_GROUPS = 19,
  parameter int unsigned       FIRST_ID   = 8,
  parameter int unsigned       ADDR_W     = 10,
  parameter logic [DATA_W-1:0] DIRECT_CAP = 32'h00BF_E000
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bus_wr,
  input  logic                         bus_rd,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic [DATA_W-1:0]            bus_wdata,
  output logic [DATA_W-1:0]            bus_rdata,
  input  logic [NUM_GROUPS*DATA_W-1:0] src_in,
  output logic [NUM_GROUPS-1:0]        grp_irq,
  output logic [NUM_GROUPS*DATA_W-1:0] direct_irq
);

  localparam int unsigned SRC_TOTAL = NUM_GROUPS * DATA_W;

  logic [1:0]            rsync_q;
  logic                  rst_sync_n;
  logic [DATA_W-1:0]     grp_rd [NUM_GROUPS];
  logic [DATA_W-1:0]     glb_rd;
  logic [SRC_TOTAL-1:0]  result_all;
  logic [NUM_GROUPS-1:0] blk_grp;
  logic                  dir_en;
  logic [DATA_W-1:0]     rd_mux;
  logic [DATA_W-1:0]     rdata_q, rdata_d;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sync_n = rsync_q[1];

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_win
    aggr_group #(
      .ADDR_W (ADDR_W),
      .BASE   (g * WIN_BYTES),
      .IMPL   (impl_mask_of(g))
    ) i_group (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .src       (src_in[g*DATA_W +: DATA_W]),
      .rd_val    (grp_rd[g]),
      .result    (result_all[g*DATA_W +: DATA_W])
    );
  end

  aggr_glb_ctrl #(
    .ADDR_W     (ADDR_W),
    .NUM_GROUPS (NUM_GROUPS),
    .FIRST_ID   (FIRST_ID)
  ) i_glb (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .rd_val    (glb_rd),
    .blk_grp   (blk_grp),
    .dir_en    (dir_en)
  );

  aggr_out_stage #(
    .NUM_GROUPS (NUM_GROUPS),
    .FIRST_ID   (FIRST_ID),
    .DIRECT_CAP (DIRECT_CAP)
  ) i_out (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .result_all (result_all),
    .blk_grp    (blk_grp),
    .dir_en     (dir_en),
    .grp_irq    (grp_irq),
    .direct_irq (direct_irq)
  );

  // every decoder returns 0 when not addressed, so an OR merges them
  always_comb begin
    rd_mux = glb_rd;
    for (int g = 0; g < int'(NUM_GROUPS); g++) rd_mux = rd_mux | grp_rd[g];
    rdata_d = bus_rd ? rd_mux : '0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rdata_q <= '0;
    else             rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;

  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !bus_rd |=> (bus_rdata == '0)); // R10

endmodule

// File: tb/test_grp_irq_aggr.sv
`timescale 1ns/1ps
module test_grp_irq_aggr;

  localparam int NG  = 19;
  localparam int SRC = NG * 32;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            bus_wr, bus_rd;
  logic [9:0]      bus_addr;
  logic [31:0]     bus_wdata;
  logic [31:0]     bus_rdata;
  logic [SRC-1:0]  src_in;
  logic [NG-1:0]   grp_irq;
  logic [SRC-1:0]  direct_irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  grp_irq_aggr i_grp_irq_aggr (
    .clk, .rst_n, .bus_wr, .bus_rd, .bus_addr, .bus_wdata, .bus_rdata,
    .src_in, .grp_irq, .direct_irq
  );

  // {req[3:0], is_read, addr[9:0], wdata[31:0], expected[31:0]}
  localparam int NV = 20;
  localparam logic [78:0] TBL [NV] = '{
    {4'd1,  1'b1, 10'h208, 32'h0,         32'h0},          // R1 block enables cleared
    {4'd1,  1'b1, 10'h000, 32'h0,         32'h0},          // R1 status cleared
    {4'd4,  1'b0, 10'h004, 32'h0000_00FF, 32'h0},
    {4'd4,  1'b1, 10'h004, 32'h0,         32'h0000_00FF},  // R4 set
    {4'd4,  1'b0, 10'h008, 32'h0000_000F, 32'h0},
    {4'd4,  1'b1, 10'h008, 32'h0,         32'h0000_00F0},  // R4 clear
    {4'd4,  1'b0, 10'h008, 32'h0,         32'h0},
    {4'd4,  1'b0, 10'h004, 32'h0,         32'h0},
    {4'd4,  1'b1, 10'h004, 32'h0,         32'h0000_00F0},  // R4 zeros ignored
    {4'd7,  1'b0, 10'h200, 32'hFFFF_FFFF, 32'h0},
    {4'd7,  1'b1, 10'h208, 32'h0,         32'h07FF_FF00},  // R7 only 8..26
    {4'd7,  1'b0, 10'h204, 32'h0000_0101, 32'h0},
    {4'd7,  1'b1, 10'h208, 32'h0,         32'h07FF_FE00},  // R7 clear
    {4'd10, 1'b1, 10'h010, 32'h0,         32'h0},          // R10 reserved
    {4'd10, 1'b1, 10'h17C, 32'h0,         32'h0},          // R10 past last window
    {4'd10, 1'b1, 10'h3F0, 32'h0,         32'h0},          // R10 unmapped
    {4'd9,  1'b0, 10'h0F4, 32'hFFFF_FFFF, 32'h0},
    {4'd9,  1'b1, 10'h0F8, 32'h0,         32'h0000_0208},  // R9 sparse enables
    {4'd8,  1'b0, 10'h20C, 32'h0000_0001, 32'h0},
    {4'd8,  1'b1, 10'h20C, 32'h0,         32'h0000_0001}   // R8 readback
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic pulse(input logic [SRC-1:0] s);
    @(negedge clk);
    src_in = s;
    @(negedge clk);
    src_in = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    logic [31:0] v;
    bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0; src_in = '0; rst_n = 1'b1;
    do_reset();

    chk("R1 grp_irq", 32'(grp_irq), 32'h0);
    chk("R1 direct", 32'(|direct_irq), 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (TBL[i][74]) begin
        rd(TBL[i][73:64], v);
        chk($sformatf("R%0d vector %0d", TBL[i][78:75], i), v, TBL[i][31:0]);
      end else begin
        wr(TBL[i][73:64], TBL[i][63:32]);
      end
    end

    // group index 0: enable 0xF0, block bit 8 off, not direct capable
    pulse(SRC'(32'h10));
    rd(10'h000, v); chk("R2 latch", v, 32'h10);
    rd(10'h00C, v); chk("R5 result", v, 32'h10);
    chk("R6 gated off", 32'(grp_irq[0]), 32'h0);
    chk("R8 not capable", direct_irq[31:0], 32'h0);
    wr(10'h200, 32'h100);
    chk("R6 gated on", 32'(grp_irq[0]), 32'h1);
    wr(10'h00C, 32'hFFFF_FFFF);
    rd(10'h00C, v); chk("R5 read-only", v, 32'h10);
    wr(10'h000, 32'h0);
    rd(10'h000, v); chk("R2 zero write", v, 32'h10);
    wr(10'h000, 32'h10);
    rd(10'h000, v); chk("R2 w1c", v, 32'h0);
    chk("R6 drops", 32'(grp_irq[0]), 32'h0);

    // R3: source and clear of the same bit together
    @(negedge clk);
    src_in = SRC'(32'h20); bus_wr = 1'b1; bus_addr = 10'h000; bus_wdata = 32'h20;
    @(negedge clk);
    src_in = '0; bus_wr = 1'b0; bus_wdata = '0;
    rd(10'h000, v); chk("R3 set wins", v, 32'h20);
    wr(10'h000, 32'h20);
    rd(10'h000, v); chk("R3 cleared after", v, 32'h0);

    // R9 / R8: group index 12, positions 3 and 9 only, direct capable
    pulse({32'hFFFF_FFFF, 384'h0});
    rd(10'h0F0, v); chk("R9 sparse latch", v, 32'h0000_0208);
    rd(10'h0FC, v); chk("R5 sparse result", v, 32'h0000_0208);
    chk("R8 direct slice", direct_irq[12*32 +: 32], 32'h0000_0208);
    chk("R6 group 20", 32'(grp_irq[12]), 32'h1);
    wr(10'h20C, 32'h0);
    chk("R8 direct off", direct_irq[12*32 +: 32], 32'h0);
    chk("R6 unaffected", 32'(grp_irq[12]), 32'h1);

    // R1: reset in the middle of activity
    do_reset();
    chk("R1 grp_irq after reset", 32'(grp_irq), 32'h0);
    rd(10'h0F0, v); chk("R1 status after reset", v, 32'h0);
    rd(10'h0F4, v); chk("R1 enable after reset", v, 32'h0);

    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

endmodule